// File: doc/BRIEF.md
# Strided Tensor Access Pattern Walker

This block turns one packed access-pattern descriptor into the sequence of element byte addresses that the descriptor describes. A descriptor names a 29-bit byte start address, one signed stride per free dimension (in element units) and one unsigned element count per free dimension. The walker supports 2, 3 or 4 free dimensions, chosen by a parameter. It scales the strides by an element size of 1, 2 or 4 bytes, which is given alongside the descriptor.

A client presents a descriptor and pulses `start_i` while the block is idle. In that same cycle the block checks the descriptor. If the descriptor is rejected, `err_o` pulses once and the block stays idle. If it is accepted, the block walks the nested loops with dimension 0 innermost. It offers one address per cycle on a valid/ready pair and raises `done_o` alongside the final address. A dimension that is not in use is padded with stride 1 and count 1, so it runs exactly once.

Top module: `tensor_walk`

## Requirements
- R1: The descriptor input is little-endian bytes. The start word is `desc_i[31:0]`. Stride i sits at bit 32+16i. Count i sits at bit 32+16N+16i. Only the low 29 bits of the start word (mask 0x1FFFFFFF) form the base address. Bits 29 to 30 are otherwise ignored.
- R2: Addresses come out with dimension 0 innermost. Each address is base + ((sum of index_i * stride_i) << esz_i), taken modulo 2^32.
- R3: The element size code `esz_i` gives 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 rejects the descriptor.
- R4: A count of zero in any dimension rejects the descriptor. On a reject, `err_o` is high for exactly the one cycle after the start edge, and no address is offered.
- R5: A start word whose byte 3 gives (byte3 & 0x70) == 0x40 is rejected.
- R6: A start word with bit 31 set is rejected.
- R7: Strides are 16-bit two's complement, so negative strides walk to lower addresses.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, the address and the valid signal hold steady.
- R9: `done_o` is high only while the last address is being offered. After that address is accepted, `busy_o` and `addr_valid_o` are low on the next cycle.
- R10: A `start_i` pulse while busy is ignored. The walk in progress continues unchanged and no error is raised.
- R11: A padded dimension (stride 1, count 1) runs once. The number of addresses equals the product of the counts.
- R12: After reset, `busy_o`, `addr_valid_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load strobe for the descriptor, taken only when idle |
| desc_i | input | 32+32*NDIM | Packed descriptor |
| esz_i | input | 2 | Element size code |
| addr_ready_i | input | 1 | Consumer is ready for an address |
| addr_o | output | 32 | Element byte address |
| addr_valid_o | output | 1 | Address is valid |
| done_o | output | 1 | The current address is the last one |
| err_o | output | 1 | One-cycle pulse when a descriptor is rejected |
| busy_o | output | 1 | A walk is in progress |

## Verification
A start strobe sampled at edge k gives its result right after that edge. On an accept, `busy_o`, `addr_valid_o` and the first address appear then. On a reject, `err_o` appears then and drops one cycle later. Each accepted address is replaced by the next one right after the handshake edge. The first idle cycle follows the last handshake edge. The bench drives inputs on the falling edge and samples every output on the following falling edge, so each result is read exactly one register stage after the edge that produced it. A stall is checked on every held cycle against the same expected address.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int unsigned TW_FIELD_W = 16;
   localparam int unsigned TW_WORD_W  = 32;
   localparam int unsigned TW_BASE_W  = 29;

   typedef enum logic [1:0] {
      ESZ_B1  = 2'd0,
      ESZ_B2  = 2'd1,
      ESZ_B4  = 2'd2,
      ESZ_BAD = 2'd3
   } esz_e;

   function automatic int unsigned tw_desc_bits(input int unsigned ndim);
      return TW_WORD_W + 2 * TW_FIELD_W * ndim;
   endfunction

   function automatic int unsigned tw_off_bits(input int unsigned ndim);
      return 2 * TW_FIELD_W + $clog2(ndim) + 1;
   endfunction
endpackage

// File: rtl/tw_desc_check.sv
module tw_desc_check
   import tw_pkg::*;
#(
   parameter int unsigned NDIM = 4
) (
   input  logic [TW_WORD_W-1:0]             word_i,
   input  logic [NDIM-1:0][TW_FIELD_W-1:0]  cnt_i,
   input  logic [1:0]                       esz_i,
   output logic                             bad_o
);
   logic [7:0]      top_byte;
   logic [NDIM-1:0] zero_cnt;

   assign top_byte = word_i[31:24];

   for (genvar d = 0; d < NDIM; d++) begin : g_zero
      assign zero_cnt[d] = (cnt_i[d] == '0);
   end

   always_comb begin
      bad_o = |zero_cnt;
      if ((top_byte & 8'h70) == 8'h40) bad_o = 1'b1;
      if (top_byte[7])                 bad_o = 1'b1;
      if (esz_e'(esz_i) == ESZ_BAD)    bad_o = 1'b1;
   end
endmodule

// File: rtl/tw_nest.sv
module tw_nest
   import tw_pkg::*;
#(
   parameter int unsigned NDIM  = 4,
   parameter int unsigned OFF_W = 35
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_i,
   input  logic [NDIM-1:0][TW_FIELD_W-1:0]  stride_i,
   input  logic [NDIM-1:0][TW_FIELD_W-1:0]  cnt_i,
   input  logic                             advance_i,
   output logic signed [OFF_W-1:0]          off_o,
   output logic                             last_o
);
   logic [NDIM-1:0][TW_FIELD_W-1:0] idx_q, cnt_q, str_q;
   logic [NDIM-1:0][OFF_W-1:0]      run_q, run_nx;
   logic [NDIM-1:0]                 at_max, bump;
   logic [NDIM:0]                   low_max;

   assign low_max[0] = 1'b1;

   for (genvar d = 0; d < NDIM; d++) begin : g_dim
      logic [OFF_W-1:0] str_ext;
      assign str_ext   = {{(OFF_W-TW_FIELD_W){str_q[d][TW_FIELD_W-1]}}, str_q[d]};
      assign at_max[d] = (idx_q[d] == cnt_q[d] - 1'b1);
      assign low_max[d+1] = low_max[d] & at_max[d];
      assign bump[d]   = low_max[d] & ~at_max[d];

      if (d == NDIM - 1) begin : g_top
         assign run_nx[d] = bump[d] ? run_q[d] + str_ext : run_q[d];
      end else begin : g_inner
         assign run_nx[d] = bump[d] ? run_q[d] + str_ext : run_nx[d+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q[d] <= '0;
            run_q[d] <= '0;
            cnt_q[d] <= '0;
            str_q[d] <= '0;
         end else if (load_i) begin
            idx_q[d] <= '0;
            run_q[d] <= '0;
            cnt_q[d] <= cnt_i[d];
            str_q[d] <= stride_i[d];
         end else if (advance_i && low_max[d]) begin
            idx_q[d] <= bump[d] ? idx_q[d] + 1'b1 : '0;
            run_q[d] <= run_nx[d];
         end
      end
   end

   assign off_o  = signed'(run_q[0]);
   assign last_o = low_max[NDIM];

   AST_INNER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      advance_i && !at_max[0] |=> off_o == $past(off_o) + signed'({{(OFF_W-TW_FIELD_W){$past(str_q[0][TW_FIELD_W-1])}}, $past(str_q[0])})); // R2
endmodule

// File: rtl/tensor_walk.sv
module tensor_walk
   import tw_pkg::*;
#(
   parameter int unsigned NDIM   = 4,
   localparam int unsigned DESC_W = tw_desc_bits(NDIM),
   localparam int unsigned OFF_W  = tw_off_bits(NDIM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DESC_W-1:0] desc_i,
   input  logic [1:0]        esz_i,
   input  logic              addr_ready_i,
   output logic [31:0]       addr_o,
   output logic              addr_valid_o,
   output logic              done_o,
   output logic              err_o,
   output logic              busy_o
);
   if (NDIM < 2 || NDIM > 4) begin : g_bad_ndim
      $error("tensor_walk: NDIM must be 2, 3 or 4");
   end

   localparam int unsigned CNT_LSB = TW_WORD_W + TW_FIELD_W * NDIM;

   logic [NDIM-1:0][TW_FIELD_W-1:0] str_w, cnt_w;
   logic [TW_WORD_W-1:0]            word_w;
   logic                            bad_w, accept, advance, last_w;
   logic                            busy_q, err_q;
   logic [TW_BASE_W-1:0]            base_q;
   logic [1:0]                      esz_q;
   logic signed [OFF_W-1:0]         off_w;
   logic signed [OFF_W+1:0]         scaled;

   assign word_w = desc_i[TW_WORD_W-1:0];

   for (genvar d = 0; d < NDIM; d++) begin : g_unpack
      assign str_w[d] = desc_i[TW_WORD_W + TW_FIELD_W*d +: TW_FIELD_W];
      assign cnt_w[d] = desc_i[CNT_LSB + TW_FIELD_W*d +: TW_FIELD_W];
   end

   tw_desc_check #(.NDIM(NDIM)) u_check (
      .word_i (word_w),
      .cnt_i  (cnt_w),
      .esz_i  (esz_i),
      .bad_o  (bad_w)
   );

   assign accept  = start_i & ~busy_q;
   assign advance = busy_q & addr_ready_i;

   tw_nest #(.NDIM(NDIM), .OFF_W(OFF_W)) u_nest (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept & ~bad_w),
      .stride_i  (str_w),
      .cnt_i     (cnt_w),
      .advance_i (advance),
      .off_o     (off_w),
      .last_o    (last_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         base_q <= '0;
         esz_q  <= '0;
      end else begin
         err_q <= accept & bad_w;
         if (accept && !bad_w) begin
            busy_q <= 1'b1;
            base_q <= word_w[TW_BASE_W-1:0];
            esz_q  <= esz_i;
         end else if (advance && last_w) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign scaled       = {{2{off_w[OFF_W-1]}}, off_w} <<< esz_q;
   assign addr_o       = {{(32-TW_BASE_W){1'b0}}, base_q} + scaled[31:0];
   assign addr_valid_o = busy_q;
   assign done_o       = busy_q & last_w;
   assign err_o        = err_q;
   assign busy_o       = busy_q;

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !addr_valid_o); // R4
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o)); // R8
   AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> addr_valid_o); // R9
   AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && addr_ready_i |=> !busy_o && !addr_valid_o); // R9
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> !err_o); // R10
endmodule

// File: tb/tensor_walk_bench.sv
module tensor_walk_bench;
   localparam int NDIM = 3;
   localparam int DW   = 32 + 32*NDIM;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] desc_i = '0;
   logic [1:0]    esz_i = 2'd0;
   logic          addr_ready_i = 1'b0;
   logic [31:0]   addr_o;
   logic          addr_valid_o, done_o, err_o, busy_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tensor_walk #(.NDIM(NDIM)) u_tensor_walk (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_i(desc_i),
      .esz_i(esz_i), .addr_ready_i(addr_ready_i), .addr_o(addr_o),
      .addr_valid_o(addr_valid_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
   );

   function automatic void chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endfunction

   function automatic logic [DW-1:0] pack(input logic [31:0] w, input int s0, s1, s2, c0, c1, c2);
      logic [15:0] a0, a1, a2, b0, b1, b2;
      a0 = 16'(s0); a1 = 16'(s1); a2 = 16'(s2);
      b0 = 16'(c0); b1 = 16'(c1); b2 = 16'(c2);
      return {b2, b1, b0, a2, a1, a0, w};
   endfunction

   task automatic walk(input logic [31:0] w, input int s0, s1, s2, c0, c1, c2,
                       input int ez, input bit stall, input bit poke, input string req);
      int n = 0;
      @(negedge clk);
      desc_i = pack(w, s0, s1, s2, c0, c1, c2);
      esz_i = 2'(ez);
      start_i = 1'b1;
      addr_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1 && err_o === 1'b0, {req, " accept"}, busy_o, 1);
      for (int i2 = 0; i2 < c2; i2++)
         for (int i1 = 0; i1 < c1; i1++)
            for (int i0 = 0; i0 < c0; i0++) begin
               longint off = longint'(i0)*s0 + longint'(i1)*s1 + longint'(i2)*s2;
               logic [31:0] exp = (w & 32'h1FFF_FFFF) + 32'(off <<< ez);
               bit last = (i0 == c0-1) && (i1 == c1-1) && (i2 == c2-1);
               int stalls = stall ? (n % 3) : 0;
               for (int k = 0; k < stalls; k++) begin
                  addr_ready_i = 1'b0;
                  chk(addr_valid_o === 1'b1 && addr_o === exp, "R8 stall hold", addr_o, exp);
                  @(negedge clk);
               end
               addr_ready_i = 1'b1;
               chk(addr_valid_o === 1'b1 && addr_o === exp, req, addr_o, exp);
               chk(done_o === last, "R9 done timing", done_o, last);
               chk(err_o === 1'b0, "R10 no error while busy", err_o, 0);
               if (poke && n == 0) begin
                  desc_i = pack(32'h0, 1, 1, 1, 0, 0, 0);
                  start_i = 1'b1;
               end
               @(negedge clk);
               start_i = 1'b0;
               n++;
            end
      addr_ready_i = 1'b0;
      chk(busy_o === 1'b0 && addr_valid_o === 1'b0, "R9 idle after last", busy_o, 0);
      chk(n == c0*c1*c2, "R11 address count", n, c0*c1*c2);
   endtask

   task automatic reject(input logic [31:0] w, input int c0, c1, c2, input int ez, input string req);
      @(negedge clk);
      desc_i = pack(w, 1, 1, 1, c0, c1, c2);
      esz_i = 2'(ez);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o === 1'b1 && addr_valid_o === 1'b0, req, err_o, 1);
      @(negedge clk);
      chk(err_o === 1'b0 && busy_o === 1'b0, {req, " pulse ends"}, err_o, 0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o === 0 && addr_valid_o === 0 && done_o === 0 && err_o === 0, "R12 reset state", busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 0 && addr_valid_o === 0 && done_o === 0 && err_o === 0, "R12 idle after reset", busy_o, 0);

      // R2 R3 R7 sweep over counts, element sizes and mixed-sign strides
      for (int ez = 0; ez < 3; ez++)
         for (int c0 = 1; c0 <= 3; c0++)
            for (int c1 = 1; c1 <= 3; c1++)
               for (int c2 = 1; c2 <= 2; c2++)
                  walk(32'h0000_4000 + 32'(c0*64), (ez == 1) ? -1 : 2, c0*3 - 7, 100 - c1*40,
                       c0, c1, c2, ez, (c1 == 2), 1'b0, "R2 R3 R7 sweep");

      walk(32'h6000_0100, 5, 7, 11, 2, 2, 2, 0, 1'b0, 1'b0, "R1 mode bits masked");
      walk(32'h1FFF_FFF0, -32768, 32767, -1, 2, 2, 2, 2, 1'b1, 1'b0, "R7 extreme strides wrap");
      walk(32'h0000_0200, 4, 1, 1, 5, 1, 1, 1, 1'b0, 1'b0, "R11 padded dims");
      walk(32'h0000_0800, 3, -8, 2, 3, 2, 2, 2, 1'b1, 1'b1, "R10 start ignored while busy");

      reject(32'h0000_0000, 0, 2, 2, 0, "R4 zero count dim0");
      reject(32'h0000_0000, 2, 0, 2, 0, "R4 zero count dim1");
      reject(32'h0000_0000, 2, 2, 0, 0, "R4 zero count dim2");
      reject(32'h4000_0000, 2, 2, 2, 0, "R5 sub-region reject");
      reject(32'h4F00_0000, 2, 2, 2, 1, "R5 sub-region reject low nibble");
      reject(32'h8000_0000, 2, 2, 2, 0, "R6 sign bit reject");
      reject(32'hA000_0000, 2, 2, 2, 2, "R6 sign bit with bit 29");
      reject(32'h0000_0000, 2, 2, 2, 3, "R3 element size code 3");

      walk(32'h5000_0000, 1, 2, 4, 2, 1, 1, 0, 1'b0, 1'b0, "R5 0x50 accepted");
      walk(32'h3000_0010, 1, 1, 1, 1, 1, 1, 2, 1'b0, 1'b0, "R1 single element");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule